// File: doc/BRIEF.md
# Front Panel Examine Sequencer

This block sits behind a toggle-switch console on an 8-bit microcomputer bus. It makes the bus clock. The clock runs freely in run mode. When the machine is halted, it gives exactly one clock per step press. The block cleans up the console push buttons with a synchronizer and a debounce filter. It also picks what the address and data lamps display.

The block does not drive the address lines to examine a memory location. It pulls the active-low interrupt request instead. When the processor answers with an interrupt-acknowledge read, the block feeds it a three-byte jump instruction built from the switches: the opcode 0xC3, then the low address byte, then the high address byte. The processor then fetches from the requested address on its own. The reset button holds the bus reset line low and aborts any sequence that is in progress. The deposit and clear buttons are only filtered. They leave as single-cycle pulses for the memory side.

All inputs are taken as synchronous to `clk_i`, except the raw buttons. The pins are plain level and strobe signals with no handshake. The processor paces the byte transfer through its own acknowledge and read strobes, and the block never stalls it.

Top module: `fp_examine_seq`

## Requirements
- R1: In run mode, `bus_clk_o` toggles every HALF = CLK_HZ/(2*BUS_HZ) system cycles, so each high phase and each low phase lasts exactly HALF cycles.
- R2: After reset and after a STOP press the block is in step mode. In step mode `sstep_o` is 1 and the bus clock rests low once any high phase in progress completes. A RUN press clears `sstep_o` to 0.
- R3: In step mode, each STEP press produces exactly one high pulse of HALF cycles on `bus_clk_o`. A STEP press in run mode does nothing.
- R4: A button acts only after its synchronized level has held for DEB_CYCLES consecutive cycles. A shorter press has no effect.
- R5: An EXAMINE press drives `pint_no` low. It stays low until a cycle in which `sinta_i` and `pdbin_i` are both 1, and then returns high.
- R6: The injected bytes are 0xC3, then target[7:0], then target[15:8]. One byte is sent per read strobe, where a read strobe is one period in which `sinta_i` and `pdbin_i` are both high. `dbus_oe_o` rises only in the cycle after both strobes are seen high. `dbus_o` is 0 whenever the enable is low.
- R7: `dbus_oe_o` is 0 no later than one cycle after `pdbin_i` falls.
- R8: EXAMINE takes its target from `sw_i`. EXAMINE NEXT takes the target of the last completed sequence plus one, wrapping from 0xFFFF to 0x0000. After reset that stored target is 0.
- R9: An EXAMINE or EXAMINE NEXT press during a running sequence is ignored. It changes neither the bytes in flight nor anything after the sequence ends.
- R10: The lamps show `bus_addr_i` and `bus_data_i` only in run mode with no sequence active. Otherwise they show `sw_i` and `sw_i[7:0]`.
- R11: A RESET press holds `preset_no` low for RESET_CYCLES cycles. It also aborts any sequence, leaving `pint_no` at 1 and `dbus_oe_o` at 0.
- R12: DEPOSIT, DEPOSIT NEXT and CLR each give exactly one single-cycle pulse per press, on `dep_o`, `dep_next_o` and `clr_o` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_i | input | 16 | Address/sense switches; the low 8 bits double as data switches |
| btn_i | input | 9 | Raw buttons, 1 = pressed: 0 STOP, 1 RUN, 2 STEP, 3 EXAMINE, 4 EXAMINE NEXT, 5 DEPOSIT, 6 DEPOSIT NEXT, 7 RESET, 8 CLR |
| bus_addr_i | input | 16 | Live bus address |
| bus_data_i | input | 8 | Live bus data |
| sinta_i | input | 1 | Interrupt-acknowledge status |
| pdbin_i | input | 1 | Data-bus-in read strobe |
| bus_clk_o | output | 1 | Generated bus clock |
| sstep_o | output | 1 | Step-mode indicator |
| pint_no | output | 1 | Interrupt request, active low |
| preset_no | output | 1 | Bus reset, active low |
| dbus_o | output | 8 | Injected byte |
| dbus_oe_o | output | 1 | Data-bus drive enable |
| lamp_addr_o | output | 16 | Address lamp value |
| lamp_data_o | output | 8 | Data lamp value |
| dep_o | output | 1 | Deposit pulse |
| dep_next_o | output | 1 | Deposit-next pulse |
| clr_o | output | 1 | Clear pulse |

## Verification
The bench goes after these corner cases:

- **Byte order.** It lowers the read strobe between injected bytes and checks that the drive enable drops within one cycle. A design that holds the enable until the acknowledge ends would collide with the next driver on the data lines. A design that advances the byte index on the wrong edge would send the bytes out of order.
- **Retrigger while busy.** It presses EXAMINE mid-sequence with different switches. A design that retriggers would corrupt the address bytes or raise a second interrupt request.
- **Address wrap.** It checks the 0xFFFF to 0x0000 wrap on EXAMINE NEXT.
- **Button filtering.** It checks that a press shorter than the debounce window is ignored.
- **Single step.** It counts clock edges per step press, to catch a stepper that emits two pulses or none.
- **Reset length.** It measures the reset-pulse length.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int NBTN      = 9;
  localparam int BTN_STOP  = 0;
  localparam int BTN_RUN   = 1;
  localparam int BTN_STEP  = 2;
  localparam int BTN_EXAM  = 3;
  localparam int BTN_EXAMN = 4;
  localparam int BTN_DEP   = 5;
  localparam int BTN_DEPN  = 6;
  localparam int BTN_RST   = 7;
  localparam int BTN_CLR   = 8;

  localparam logic [7:0] JMP_OPCODE = 8'hC3;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_BYTE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fp_debounce.sv
module fp_debounce #(
  parameter int DEB_CYCLES = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic press_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [1:0]    sync_q;
  logic          stable_q;
  logic [CW-1:0] cnt_q;
  logic          press_q;
  logic          settle;

  assign settle = (cnt_q == CW'(DEB_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      press_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], raw_i};
      press_q <= 1'b0;
      if (sync_q[1] == stable_q) begin
        cnt_q <= '0;
      end else if (settle) begin
        stable_q <= sync_q[1];
        cnt_q    <= '0;
        press_q  <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign press_o = press_q;

  // R4 / R12: a press yields a single-cycle event
  assert_single_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o);
endmodule

// File: rtl/fp_busclk.sv
module fp_busclk #(
  parameter int HALF = 62
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_en_i,
  input  logic step_i,
  output logic clk_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          clk_q;
  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (step_i && !run_en_i) pend_q <= 1'b1;
      if (clk_q || run_en_i) begin
        if (wrap) begin
          cnt_q <= '0;
          clk_q <= !clk_q;
          if (!clk_q) pend_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (pend_q) begin
        clk_q  <= 1'b1;
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign clk_o = clk_q;

  // R1: a high phase always ends after a full count
  assert_half_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_o) |-> ($past(cnt_q) == CW'(HALF - 1)));
  // R3: in step mode a rising edge needs a pending step request
  assert_step_one_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clk_o) && !$past(run_en_i)) |-> $past(pend_q));
endmodule

// File: rtl/fp_inject.sv
module fp_inject
  import fp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        abort_i,
  input  logic        start_exam_i,
  input  logic        start_next_i,
  input  logic [15:0] sw_addr_i,
  input  logic        sinta_i,
  input  logic        pdbin_i,
  output logic        pint_no,
  output logic [7:0]  dbus_o,
  output logic        dbus_oe_o,
  output logic        busy_o
);
  seq_state_e  st_q;
  logic [1:0]  idx_q;
  logic [15:0] tgt_q;
  logic [15:0] last_q;
  logic        oe_q;
  logic        ack;
  logic [7:0]  byte_sel;

  assign ack = sinta_i && pdbin_i;

  always_comb begin
    unique case (idx_q)
      2'd0:    byte_sel = JMP_OPCODE;
      2'd1:    byte_sel = tgt_q[7:0];
      default: byte_sel = tgt_q[15:8];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      tgt_q  <= '0;
      last_q <= '0;
      oe_q   <= 1'b0;
    end else if (abort_i) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          oe_q  <= 1'b0;
          idx_q <= '0;
          if (start_exam_i) begin
            tgt_q <= sw_addr_i;
            st_q  <= SQ_REQ;
          end else if (start_next_i) begin
            tgt_q <= last_q + 16'd1;
            st_q  <= SQ_REQ;
          end
        end
        SQ_REQ: begin
          if (ack) begin
            oe_q <= 1'b1;
            st_q <= SQ_BYTE;
          end
        end
        default: begin
          oe_q <= ack;
          if (oe_q && !ack) begin
            if (idx_q == 2'd2) begin
              st_q   <= SQ_IDLE;
              last_q <= tgt_q;
              idx_q  <= '0;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
          end
        end
      endcase
    end
  end

  assign pint_no   = (st_q != SQ_REQ);
  assign dbus_oe_o = oe_q;
  assign dbus_o    = oe_q ? byte_sel : 8'h00;
  assign busy_o    = (st_q != SQ_IDLE);

  // R7: drive released within one cycle of the read strobe falling
  assert_oe_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!pdbin_i) |-> !dbus_oe_o);
  // R6: drive only follows a cycle with both strobes high
  assert_drive_after_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbus_oe_o |-> $past(sinta_i && pdbin_i));
  // R9: target frozen while a sequence runs
  assert_target_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> $stable(tgt_q));
endmodule

// File: rtl/fp_examine_seq.sv
module fp_examine_seq
  import fp_pkg::*;
#(
  parameter int CLK_HZ       = 250000000,
  parameter int BUS_HZ       = 2000000,
  parameter int DEB_CYCLES   = 1250000,
  parameter int RESET_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      sw_i,
  input  logic [NBTN-1:0]  btn_i,
  input  logic [15:0]      bus_addr_i,
  input  logic [7:0]       bus_data_i,
  input  logic             sinta_i,
  input  logic             pdbin_i,
  output logic             bus_clk_o,
  output logic             sstep_o,
  output logic             pint_no,
  output logic             preset_no,
  output logic [7:0]       dbus_o,
  output logic             dbus_oe_o,
  output logic [15:0]      lamp_addr_o,
  output logic [7:0]       lamp_data_o,
  output logic             dep_o,
  output logic             dep_next_o,
  output logic             clr_o
);
  localparam int HALF = CLK_HZ / (2 * BUS_HZ);
  localparam int RCW  = $clog2(RESET_CYCLES + 1);

  logic [NBTN-1:0] press;
  logic            run_q;
  logic [RCW-1:0]  rst_cnt_q;
  logic            busy;
  logic            abort;

  for (genvar b = 0; b < NBTN; b++) begin : g_btn
    fp_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (btn_i[b]),
      .press_o (press[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      rst_cnt_q <= '0;
    end else begin
      if (press[BTN_STOP])     run_q <= 1'b0;
      else if (press[BTN_RUN]) run_q <= 1'b1;
      if (press[BTN_RST])          rst_cnt_q <= RCW'(RESET_CYCLES);
      else if (rst_cnt_q != '0)    rst_cnt_q <= rst_cnt_q - 1'b1;
    end
  end

  assign preset_no = (rst_cnt_q == '0);
  assign abort     = press[BTN_RST] || (rst_cnt_q != '0);

  fp_busclk #(.HALF(HALF)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_en_i (run_q || busy),
    .step_i   (press[BTN_STEP]),
    .clk_o    (bus_clk_o)
  );

  fp_inject u_inj (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .abort_i      (abort),
    .start_exam_i (press[BTN_EXAM]),
    .start_next_i (press[BTN_EXAMN]),
    .sw_addr_i    (sw_i),
    .sinta_i      (sinta_i),
    .pdbin_i      (pdbin_i),
    .pint_no      (pint_no),
    .dbus_o       (dbus_o),
    .dbus_oe_o    (dbus_oe_o),
    .busy_o       (busy)
  );

  assign sstep_o     = !run_q;
  assign lamp_addr_o = (run_q && !busy) ? bus_addr_i : sw_i;
  assign lamp_data_o = (run_q && !busy) ? bus_data_i : sw_i[7:0];
  assign dep_o       = press[BTN_DEP];
  assign dep_next_o  = press[BTN_DEPN];
  assign clr_o       = press[BTN_CLR];

  logic [RCW:0] low_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_len_q <= '0;
    else if (preset_no) low_len_q <= '0;
    else if (low_len_q != {(RCW+1){1'b1}}) low_len_q <= low_len_q + 1'b1;
  end

  // R11: reset pulse lasts its full length
  assert_reset_len_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(preset_no) |-> ($past(low_len_q) >= (RCW+1)'(RESET_CYCLES - 1)));
  // R11: no interrupt request or drive while reset is held
  assert_reset_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preset_no |-> (pint_no && !dbus_oe_o));
  // R10: lamps show switches while a sequence is active
  assert_lamp_sw_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pint_no |-> (lamp_addr_o == sw_i));
endmodule

// File: tb/fp_examine_seq_bench.sv
module fp_examine_seq_bench;
  localparam int DEB  = 8;
  localparam int HALF = 4;
  localparam int RSTC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sw = 16'h0000;
  logic [8:0]  btn = '0;
  logic [15:0] bus_addr = 16'h1234;
  logic [7:0]  bus_data = 8'h5A;
  logic        sinta = 1'b0, pdbin = 1'b0;
  logic        bus_clk, sstep, pint_n, preset_n, oe, dep, depn, clr;
  logic [7:0]  dbus, lamp_d;
  logic [15:0] lamp_a;

  int errors = 0, checks = 0;
  int rises = 0, dep_cnt = 0, depn_cnt = 0, clr_cnt = 0, rst_low = 0;
  logic prev_clk = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  fp_examine_seq #(.CLK_HZ(16), .BUS_HZ(2), .DEB_CYCLES(DEB), .RESET_CYCLES(RSTC)) u_fp_examine_seq (
    .clk_i(clk), .rst_ni(rst_n), .sw_i(sw), .btn_i(btn), .bus_addr_i(bus_addr),
    .bus_data_i(bus_data), .sinta_i(sinta), .pdbin_i(pdbin), .bus_clk_o(bus_clk),
    .sstep_o(sstep), .pint_no(pint_n), .preset_no(preset_n), .dbus_o(dbus),
    .dbus_oe_o(oe), .lamp_addr_o(lamp_a), .lamp_data_o(lamp_d), .dep_o(dep),
    .dep_next_o(depn), .clr_o(clr));

  always @(posedge clk) begin
    prev_clk <= bus_clk;
    if (bus_clk && !prev_clk) rises <= rises + 1;
    if (dep) dep_cnt <= dep_cnt + 1;
    if (depn) depn_cnt <= depn_cnt + 1;
    if (clr) clr_cnt <= clr_cnt + 1;
    if (!preset_n) rst_low <= rst_low + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int b);
    @(negedge clk) btn[b] = 1'b1;
    cyc(DEB + 6);
    btn[b] = 1'b0;
    cyc(DEB + 6);
  endtask

  task automatic cpu_byte(input logic [7:0] exp, input string tag);
    @(negedge clk) begin sinta = 1'b1; pdbin = 1'b1; end
    @(negedge clk);
    chk(oe === 1'b1, {tag, " R6 oe"}, oe, 1);
    chk(dbus === exp, {tag, " R6 byte"}, dbus, exp);
    @(negedge clk) pdbin = 1'b0;
    @(negedge clk);
    chk(oe === 1'b0, {tag, " R7 release"}, oe, 0);
    chk(dbus === 8'h00, {tag, " R6 idle zero"}, dbus, 0);
  endtask

  task automatic cpu_seq(input logic [15:0] addr, input string tag);
    int t = 0;
    while (pint_n !== 1'b0 && t < 100) begin cyc(1); t++; end
    chk(pint_n === 1'b0, {tag, " R5 request"}, pint_n, 0);
    cpu_byte(8'hC3, tag);
    chk(pint_n === 1'b1, {tag, " R5 request dropped"}, pint_n, 1);
    cpu_byte(addr[7:0], tag);
    cpu_byte(addr[15:8], tag);
    @(negedge clk) sinta = 1'b0;
  endtask

  task automatic t_reset_state;
    chk(sstep === 1'b1, "R2 reset step mode", sstep, 1);
    chk(pint_n === 1'b1 && oe === 1'b0, "R5 reset idle", {pint_n, oe}, 2);
    chk(preset_n === 1'b1, "R11 reset line idle", preset_n, 1);
    chk(lamp_a === sw, "R10 lamps show switches", lamp_a, sw);
  endtask

  task automatic t_run;
    int hi = 0, r0;
    press(1);
    chk(sstep === 1'b0, "R2 run clears step", sstep, 0);
    chk(lamp_a === bus_addr && lamp_d === bus_data, "R10 lamps show bus", lamp_a, bus_addr);
    r0 = rises; cyc(80);
    chk(rises - r0 >= 9 && rises - r0 <= 11, "R1 run edge count", rises - r0, 10);
    while (bus_clk !== 1'b1) cyc(1);
    while (bus_clk === 1'b1) begin cyc(1); hi++; end
    chk(hi == HALF, "R1 high phase length", hi, HALF);
  endtask

  task automatic t_stop_step;
    int r0, hi = 0;
    press(0);
    cyc(10);
    r0 = rises; cyc(40);
    chk(rises == r0 && bus_clk === 1'b0, "R2 clock stopped", rises - r0, 0);
    chk(sstep === 1'b1, "R2 step indicator", sstep, 1);
    chk(lamp_a === sw, "R10 stopped lamps switches", lamp_a, sw);
    r0 = rises;
    @(negedge clk) btn[2] = 1'b1;
    while (bus_clk !== 1'b1 && hi < 40) begin cyc(1); hi++; end
    hi = 0;
    while (bus_clk === 1'b1) begin cyc(1); hi++; end
    chk(hi == HALF, "R3 step pulse length", hi, HALF);
    btn[2] = 1'b0; cyc(DEB + 20);
    chk(rises - r0 == 1, "R3 one edge per step", rises - r0, 1);
    r0 = rises; press(2); cyc(10);
    chk(rises - r0 == 1, "R3 second step", rises - r0, 1);
  endtask

  task automatic t_glitch;
    @(negedge clk) btn[3] = 1'b1;
    cyc(DEB / 2);
    btn[3] = 1'b0;
    cyc(40);
    chk(pint_n === 1'b1, "R4 short press ignored", pint_n, 1);
  endtask

  task automatic t_examine;
    sw = 16'hA55A;
    press(3);
    chk(lamp_a === 16'hA55A, "R10 busy lamps", lamp_a, 16'hA55A);
    cpu_seq(16'hA55A, "R8 examine");
    chk(pint_n === 1'b1, "R5 idle after", pint_n, 1);
  endtask

  task automatic t_busy_ignore;
    sw = 16'h3C01;
    press(3);
    @(negedge clk) begin sinta = 1'b1; pdbin = 1'b1; end
    @(negedge clk) pdbin = 1'b0;
    sw = 16'h7777;
    press(3);
    cpu_byte(8'h01, "R9 busy low");
    cpu_byte(8'h3C, "R9 busy high");
    @(negedge clk) sinta = 1'b0;
    cyc(40);
    chk(pint_n === 1'b1, "R9 no retrigger", pint_n, 1);
  endtask

  task automatic t_next;
    sw = 16'hA55A;
    press(3);
    cpu_seq(16'hA55A, "R8 base");
    press(4);
    cpu_seq(16'hA55B, "R8 next");
    sw = 16'hFFFF;
    press(3);
    cpu_seq(16'hFFFF, "R8 top");
    press(4);
    cpu_seq(16'h0000, "R8 wrap");
  endtask

  task automatic t_pulses;
    press(5); press(6); press(6); press(8);
    chk(dep_cnt == 1, "R12 deposit pulse", dep_cnt, 1);
    chk(depn_cnt == 2, "R12 deposit next pulses", depn_cnt, 2);
    chk(clr_cnt == 1, "R12 clear pulse", clr_cnt, 1);
  endtask

  task automatic t_reset_btn;
    int l0;
    sw = 16'h0100;
    press(3);
    chk(pint_n === 1'b0, "R11 pending before reset", pint_n, 0);
    l0 = rst_low;
    press(7);
    cyc(20);
    chk(rst_low - l0 == RSTC, "R11 reset length", rst_low - l0, RSTC);
    chk(pint_n === 1'b1 && oe === 1'b0, "R11 sequence aborted", {pint_n, oe}, 2);
  endtask

  task automatic t_run_busy;
    press(1);
    sw = 16'h4242;
    press(3);
    chk(lamp_a === 16'h4242 && lamp_d === 8'h42, "R10 run busy lamps", lamp_a, 16'h4242);
    cpu_seq(16'h4242, "R6 run mode");
    cyc(2);
    chk(lamp_a === bus_addr, "R10 back to bus", lamp_a, bus_addr);
    press(2);
    chk(sstep === 1'b0, "R3 step ignored in run", sstep, 0);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    t_reset_state();
    t_run();
    t_stop_step();
    t_glitch();
    t_examine();
    t_busy_ignore();
    t_next();
    t_pulses();
    t_reset_btn();
    t_run_busy();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule